// File: doc/BRIEF.md
# Interlaced Field Parity Detector

This block decides whether the field now arriving in an interlaced video stream is the odd field or the even field. It watches a digital, active-low composite sync input and measures, in system clock cycles, the interval between consecutive sync falling edges. Each interval is classed as a full line or a half line against a fraction of a nominal line period, which is a parameter.

A single toggle bit clears on every full-line interval and inverts on every half-line interval. Across the equalizing and half-line pulses around vertical blanking, it therefore holds the parity of the half-line count. A separate circuit finds the vertical sync start and reports it as a one-cycle strobe. On that strobe the toggle bit is copied into the registered field output. The output holds that value until the next strobe.

Top module: `field_parity_det`

## Requirements
- R1: A sync falling edge that follows the previous falling edge by fewer than LINE_CYCLES*3/4 clock cycles (74 or fewer when LINE_CYCLES is 100) is a half-line interval and inverts the toggle bit.
- R2: A sync falling edge that follows the previous one by LINE_CYCLES*3/4 cycles or more (75 or more when LINE_CYCLES is 100) is a full-line interval and clears the toggle bit to 0. The first falling edge after reset counts as a full-line interval.
- R3: On a cycle where `vstart` is 1, `field_odd` loads the toggle bit and shows it from the next clock edge. An odd number of half-line intervals since the last full-line interval gives 1 (odd field). An even number gives 0 (even field).
- R4: `field_odd` keeps its value in every cycle that has no `vstart` strobe, whatever the sync input does.
- R5: A synchronous active-high reset forces `field_odd` to 0 and clears the toggle bit.
- R6: The interval counter saturates and does not wrap. A gap longer than the counter range is a full-line interval. With LINE_CYCLES of 100 the counter is 9 bits wide, so a gap of 562 cycles must read as full, not as 50.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| csync_n | input | 1 | Digital composite sync, low during sync pulses, asynchronous to clk |
| vstart | input | 1 | One-cycle strobe marking the start of vertical sync |
| field_odd | output | 1 | Registered field parity: 1 for odd field, 0 for even field |

## Verification
A wrong toggle bit stays hidden until the next `vstart` strobe. At that strobe it appears as an inverted `field_odd` one clock later, so the bench places strobes straight after short, known runs of half-line and full-line intervals. Faults in the interval counter, such as a threshold off by one or a counter that wraps, show only when an interval falls at 74/75 cycles or beyond the counter range. Directed intervals at exactly those lengths, each followed by a strobe, expose them within one field sequence. An output that changes without a strobe shows at once, and the bench checks for it after bursts of edges that flip the toggle bit.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

  typedef enum logic {
    GAP_FULL = 1'b0,
    GAP_HALF = 1'b1
  } gap_kind_e;

  function automatic int cnt_width(input int line_cycles);
    return $clog2(line_cycles * 4);
  endfunction

  function automatic int half_limit(input int line_cycles);
    return (line_cycles * 3) / 4;
  endfunction

endpackage

// File: rtl/fpd_sync_edge.sv
module fpd_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din_n,
  output logic fall
);

  logic [SYNC_STAGES-1:0] chain;
  logic                   last_q;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b1;
    else     chain[0] <= din_n;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= 1'b1;
      else     chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b1;
    else     last_q <= chain[SYNC_STAGES-1];
  end

  assign fall = last_q & ~chain[SYNC_STAGES-1];

endmodule

// File: rtl/fpd_spacing.sv
module fpd_spacing
  import fpd_pkg::*;
#(
  parameter int LINE_CYCLES = 100
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      fall,
  output gap_kind_e kind
);

  localparam int              CNT_W   = cnt_width(LINE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LIM     = CNT_W'(half_limit(LINE_CYCLES));

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= CNT_MAX;
    else if (fall)           cnt_q <= {{(CNT_W-1){1'b0}}, 1'b1};
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    kind = (cnt_q < LIM) ? GAP_HALF : GAP_FULL;
  end

endmodule

// File: rtl/fpd_toggle.sv
module fpd_toggle
  import fpd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      fall,
  input  gap_kind_e kind,
  output logic      tog
);

  always_ff @(posedge clk) begin
    if (rst)                 tog <= 1'b0;
    else if (fall) begin
      if (kind == GAP_HALF)  tog <= ~tog;
      else                   tog <= 1'b0;
    end
  end

endmodule

// File: rtl/field_parity_det.sv
module field_parity_det
  import fpd_pkg::*;
#(
  parameter int LINE_CYCLES = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic csync_n,
  input  logic vstart,
  output logic field_odd
);

  logic      edge_fall;
  gap_kind_e gap_kind;
  logic      gap_half;
  logic      tog_q;

  fpd_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .din_n(csync_n),
    .fall (edge_fall)
  );

  fpd_spacing #(.LINE_CYCLES(LINE_CYCLES)) u_spacing (
    .clk (clk),
    .rst (rst),
    .fall(edge_fall),
    .kind(gap_kind)
  );

  fpd_toggle u_toggle (
    .clk (clk),
    .rst (rst),
    .fall(edge_fall),
    .kind(gap_kind),
    .tog (tog_q)
  );

  assign gap_half = (gap_kind == GAP_HALF);

  always_ff @(posedge clk) begin
    if (rst)         field_odd <= 1'b0;
    else if (vstart) field_odd <= tog_q;
  end

endmodule

// File: rtl/fpd_checker.sv
module fpd_checker (
  input logic clk,
  input logic rst,
  input logic vstart,
  input logic fall,
  input logic half,
  input logic tog,
  input logic field_odd
);

  AST_HALF_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    (fall && half) |=> (tog != $past(tog)));                          // R1

  AST_IDLE_TOG: assert property (@(posedge clk) disable iff (rst)
    (!fall) |=> $stable(tog));                                         // R1

  AST_FULL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (fall && !half) |=> !tog);                                         // R2

  AST_STROBE_LOADS: assert property (@(posedge clk) disable iff (rst)
    vstart |=> (field_odd == $past(tog)));                             // R3

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!vstart) |=> $stable(field_odd));                                 // R4

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!field_odd && !tog));                                     // R5

endmodule

bind field_parity_det fpd_checker u_fpd_chk (
  .clk      (clk),
  .rst      (rst),
  .vstart   (vstart),
  .fall     (edge_fall),
  .half     (gap_half),
  .tog      (tog_q),
  .field_odd(field_odd)
);

// File: tb/test_field_parity_det.sv
module test_field_parity_det;

  localparam int LINE  = 100;
  localparam int LIMIT = 75;   // LINE*3/4

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csync_n = 1'b1;
  logic vstart = 1'b0;
  logic field_odd;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int last_fall = -1;
  logic exp_tog = 1'b0;
  logic exp_out = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  field_parity_det #(.LINE_CYCLES(LINE), .SYNC_STAGES(2)) i_field_parity_det (
    .clk(clk), .rst(rst), .csync_n(csync_n), .vstart(vstart), .field_odd(field_odd)
  );

  function automatic logic next_tog(input logic cur, input int prev, input int now);
    if (prev >= 0 && (now - prev) < LIMIT) return ~cur;
    return 1'b0;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s field_odd act=%0b exp=%0b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Caller sits just after a negedge; total length low_w+high_w cycles.
  task automatic pulse(input int low_w, input int high_w);
    exp_tog = next_tog(exp_tog, last_fall, cyc);
    last_fall = cyc;
    csync_n = 1'b0;
    repeat (low_w) @(negedge clk);
    csync_n = 1'b1;
    repeat (high_w) @(negedge clk);
  endtask

  task automatic strobe_check(input string req);
    vstart = 1'b1;
    @(negedge clk);
    vstart = 1'b0;
    exp_out = exp_tog;
    check(req, field_odd, exp_out);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R5 reset", field_odd, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    last_fall = -1;
    strobe_check("R5 strobe before any edge");

    // Odd field: full lines then five half-line intervals.
    for (int i = 0; i < 5; i++) pulse(8, LINE - 8);
    for (int i = 0; i < 5; i++) pulse(4, LINE/2 - 4);
    pulse(8, LINE - 8);
    strobe_check("R3 odd field");

    // Output must hold through edges that clear the toggle (R4).
    for (int i = 0; i < 3; i++) pulse(8, LINE - 8);
    check("R4 hold without strobe", field_odd, exp_out);
    strobe_check("R2 full lines clear");

    // Even field: six half-line intervals.
    for (int i = 0; i < 4; i++) pulse(8, LINE - 8);
    for (int i = 0; i < 6; i++) pulse(4, LINE/2 - 4);
    pulse(8, LINE - 8);
    strobe_check("R3 even field");

    // R1 boundary: interval of 74 is half.
    pulse(8, LINE - 8);
    pulse(4, 70);
    pulse(4, LINE - 4);
    strobe_check("R1 interval 74 half");
    check("R4 hold after strobe", field_odd, exp_out);

    // R2 boundary: toggle high, then interval of 75 clears it.
    pulse(4, 46);
    pulse(4, 71);
    pulse(4, LINE - 4);
    strobe_check("R2 interval 75 full");

    // R6: gap of 562 would wrap a 9-bit counter to 50.
    pulse(8, LINE - 8);
    pulse(4, 558);
    pulse(4, LINE - 4);
    strobe_check("R6 saturating gap");

    // Constrained random intervals with occasional strobes.
    for (int i = 0; i < 80; i++) begin
      int sel;
      int sp;
      sel = int'($urandom_range(0, 3));
      if (sel == 0)      sp = LINE / 2;
      else if (sel == 1) sp = LINE;
      else               sp = int'($urandom_range(40, 140));
      pulse(6, sp - 6);
      if ($urandom_range(0, 2) == 0) strobe_check("R3 random strobe");
      else check("R4 random hold", field_odd, exp_out);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule